// File: doc/BRIEF.md
# Unlock-Guarded Byte Memory Write Controller

This block sits between a simple register bus and a byte-wide nonvolatile data store, modelled here as an internal register array. Software steers it through four registers: a pointer that selects the byte, a latch that holds the byte to be stored, a control register, and a write-only key register. Reading the data register returns the stored byte at the pointer.

A store is launched by writing the control register with its start bit set. The launch goes ahead only if the key register has just received the two-byte key and write-enable was already on. The two space-select bits must also be clear. A launched store first erases the byte to 0xFF and then programs the new value. Each phase lasts a parameterised number of clock cycles. Completion raises a one-cycle pulse and a sticky flag. A start attempt that is refused sets a sticky error flag and leaves the array untouched. The key is consumed by every start attempt, whether it succeeds or not.

Top module: `eew_ctrl`

## Requirements
- R1: After reset the pointer, the control register and the key register all read 0x00, and `done_pulse` is 0.
- R2: The register select is `bus_addr`: 0 is the pointer, 1 is the data latch, 2 is control and 3 is the key register. Reading select 1 returns the stored byte at the pointer. Reading select 3 returns 0x00. Control reads as {bit7 program-space select, bit6 config-space select, 0, bit4 done, bit3 error, bit2 write-enable, bit1 busy, 0}.
- R3: A start write is a control write with bit1 set. It launches only if the two bus writes just before it were 0x55 and then 0xAA to the key register. Any other write in between, or the wrong order, refuses the launch.
- R4: A start is refused if write-enable (bit2) was not already 1 in the control register before the start write.
- R5: A start is refused if control bit7 or bit6 was 1 before the start write.
- R6: A launched store keeps busy (control bit1) at 1 for ERASE_CYC+PROG_CYC cycles. During that time the target byte reads 0xFF. Afterwards it reads the latched value.
- R7: `done_pulse` is high for one cycle on the first cycle after busy falls. Done (bit4) is set at the same time. Writing 1 to control bit4 clears done.
- R8: A refused start sets error (bit3) and leaves the array unchanged. Writing 1 to bit3 clears error. A refused start whose own write carries bit3=1 still leaves error set.
- R9: While busy, writes to the pointer and to the data latch have no effect.
- R10: The key is used once. After any start attempt, a further start without a fresh key is refused.
- R11: If a write of 1 to bit4 lands in the same cycle the store completes, done ends up set.
- R12: A start write while busy is ignored. It neither restarts the store nor sets error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| done_pulse | output | 1 | One-cycle store-complete pulse |

## Verification
Two pairs of functions can fall in the same cycle. The first is the completion of a store and a software write-one-to-clear of the done flag. The bench times a control write so that it is captured on exactly the completion edge, then expects done to read as set. The second is a refused start and an error clear carried by one write. The bench issues a keyless start that also writes 1 to the error bit, and expects error to remain set.

// File: rtl/eew_pkg.sv
package eew_pkg;
  typedef enum logic [1:0] {
    REG_PTR  = 2'd0,
    REG_DATA = 2'd1,
    REG_CTRL = 2'd2,
    REG_KEY  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ERASE = 2'd1,
    PH_PROG  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    KS_NONE  = 2'd0,
    KS_HALF  = 2'd1,
    KS_ARMED = 2'd2
  } key_state_e;

  localparam int CB_PROG = 7;
  localparam int CB_CFG  = 6;
  localparam int CB_DONE = 4;
  localparam int CB_ERR  = 3;
  localparam int CB_WEN  = 2;
  localparam int CB_GO   = 1;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam logic [7:0] ERASED     = 8'hFF;
endpackage

// File: rtl/eew_rst_sync.sv
module eew_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/eew_key.sv
module eew_key
  import eew_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_any,
  input  logic       wr_key,
  input  logic [7:0] wdata,
  output logic       armed
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_any) begin
      if (wr_key) begin
        if (wdata == KEY_FIRST)
          state_d = KS_HALF;
        else if (wdata == KEY_SECOND && state_q == KS_HALF)
          state_d = KS_ARMED;
        else
          state_d = KS_NONE;
      end else begin
        state_d = KS_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_NONE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == KS_ARMED);

  // R3: armed is only ever entered from the half-key state
  p_armed_from_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_ARMED && $past(state_q) != KS_ARMED) |-> $past(state_q) == KS_HALF);
endmodule

// File: rtl/eew_seq.sv
module eew_seq
  import eew_pkg::*;
#(
  parameter int ERASE_CYC = 4,
  parameter int PROG_CYC  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic prog_last
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] E_LOAD = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] P_LOAD = CW'(PROG_CYC - 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (launch) begin
        phase_d = PH_ERASE;
        cnt_d   = E_LOAD;
        cnt_en  = 1'b1;
      end
      PH_ERASE: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          phase_d = PH_PROG;
          cnt_d   = P_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PROG: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) phase_d = PH_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy      = (phase_q != PH_IDLE);
  assign prog_last = (phase_q == PH_PROG) && (cnt_q == '0);

  // R6: erase always hands over to program, never straight to idle
  p_erase_then_prog_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ERASE && cnt_q == '0) |=> phase_q == PH_PROG);
  // R12: a launch request is never seen while a cycle runs
  p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
endmodule

// File: rtl/eew_array.sv
module eew_array
  import eew_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          erase_en,
  input  logic          prog_en,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (erase_en)     mem_q[waddr] <= ERASED;
    else if (prog_en) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/eew_ctrl.sv
module eew_ctrl
  import eew_pkg::*;
#(
  parameter int AW        = 8,
  parameter int ERASE_CYC = 4,
  parameter int PROG_CYC  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       done_pulse
);
  localparam int PAD = (AW < 8) ? 8 - AW : 0;

  logic          srst_n;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [7:0]    dat_q, dat_d;
  logic          prog_q, prog_d, cfg_q, cfg_d, wen_q, wen_d;
  logic          done_q, done_d, err_q, err_d, pulse_q;
  logic          wr_ptr, wr_dat, wr_ctl, wr_key;
  logic          go_req, attempt, launch, refuse;
  logic          armed, busy, prog_last;
  logic [7:0]    arr_rdata;

  eew_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  eew_key u_key (
    .clk(clk), .rst_n(srst_n), .wr_any(bus_wr), .wr_key(wr_key),
    .wdata(bus_wdata), .armed(armed)
  );

  eew_seq #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(srst_n), .launch(launch), .busy(busy), .prog_last(prog_last)
  );

  eew_array #(.AW(AW)) u_arr (
    .clk(clk), .erase_en(launch), .prog_en(prog_last), .waddr(ptr_q),
    .wdata(dat_q), .raddr(ptr_q), .rdata(arr_rdata)
  );

  // decode
  always_comb begin
    wr_ptr  = bus_wr && (bus_addr == REG_PTR);
    wr_dat  = bus_wr && (bus_addr == REG_DATA);
    wr_ctl  = bus_wr && (bus_addr == REG_CTRL);
    wr_key  = bus_wr && (bus_addr == REG_KEY);
    go_req  = wr_ctl && bus_wdata[CB_GO];
    attempt = go_req && !busy;
    launch  = attempt && armed && wen_q && !prog_q && !cfg_q;
    refuse  = attempt && !launch;
  end

  // next state
  always_comb begin
    ptr_d  = ptr_q;
    dat_d  = dat_q;
    prog_d = prog_q;
    cfg_d  = cfg_q;
    wen_d  = wen_q;
    if (wr_ptr && !busy) ptr_d = bus_wdata[AW-1:0];
    if (wr_dat && !busy) dat_d = bus_wdata;
    if (wr_ctl) begin
      prog_d = bus_wdata[CB_PROG];
      cfg_d  = bus_wdata[CB_CFG];
      wen_d  = bus_wdata[CB_WEN];
    end
    if (refuse)                         err_d = 1'b1;
    else if (wr_ctl && bus_wdata[CB_ERR]) err_d = 1'b0;
    else                                err_d = err_q;
    if (prog_last)                       done_d = 1'b1;
    else if (wr_ctl && bus_wdata[CB_DONE]) done_d = 1'b0;
    else                                 done_d = done_q;
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ptr_q   <= '0;
      dat_q   <= '0;
      prog_q  <= 1'b0;
      cfg_q   <= 1'b0;
      wen_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      dat_q   <= dat_d;
      prog_q  <= prog_d;
      cfg_q   <= cfg_d;
      wen_q   <= wen_d;
      done_q  <= done_d;
      err_q   <= err_d;
      pulse_q <= prog_last;
    end
  end

  // read mux
  always_comb begin
    unique case (bus_addr)
      REG_PTR:  bus_rdata = {{PAD{1'b0}}, ptr_q};
      REG_DATA: bus_rdata = arr_rdata;
      REG_CTRL: bus_rdata = {prog_q, cfg_q, 1'b0, done_q, err_q, wen_q, busy, 1'b0};
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign done_pulse = pulse_q;

  // R3: a cycle only starts from an armed key with the guards satisfied (R4, R5)
  p_launch_guarded_r3: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(busy) |-> $past(armed && wen_q && !prog_q && !cfg_q));
  // R9: pointer holds while busy despite bus writes
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && wr_ptr) |=> $stable(ptr_q));
  // R7: completion pulse coincides with idle and the sticky done flag
  p_done_end_r7: assert property (@(posedge clk) disable iff (!srst_n)
    pulse_q |-> (!busy && done_q));
  // R10: any start request consumes the key
  p_key_used_r10: assert property (@(posedge clk) disable iff (!srst_n)
    go_req |=> !armed);
endmodule

// File: tb/eew_ctrl_bench.sv
module eew_ctrl_bench;
  localparam int E = 4;
  localparam int P = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       done_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  eew_ctrl #(.AW(8), .ERASE_CYC(E), .PROG_CYC(P)) u_eew_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_pulse(done_pulse)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // called at a falling edge; write captured at the next rising edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic unlock();
    wr(2'd3, 8'h55);
    wr(2'd3, 8'hAA);
  endtask

  task automatic start_store(input logic [7:0] a, input logic [7:0] d);
    wr(2'd0, a);
    wr(2'd1, d);
    wr(2'd2, 8'h04);
    unlock();
    wr(2'd2, 8'h06);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 pointer", v, 8'h00);
    rd(2'd2, v); chk("R1 control", v, 8'h00);
    rd(2'd3, v); chk("R1 key", v, 8'h00);
    chk("R1 done_pulse", {7'd0, done_pulse}, 8'h00);
  endtask

  task automatic t_store();
    logic [7:0] v;
    start_store(8'h10, 8'h3C);
    rd(2'd2, v); chk("R6 busy after start", v, 8'h06);
    rd(2'd1, v); chk("R6 erased during cycle", v, 8'hFF);
    repeat (E + P - 1) @(negedge clk);
    rd(2'd2, v); chk("R6 busy on last cycle", v, 8'h06);
    rd(2'd1, v); chk("R6 still erased late", v, 8'hFF);
    @(negedge clk);
    chk("R7 done_pulse high", {7'd0, done_pulse}, 8'h01);
    rd(2'd2, v); chk("R7 done set busy clear", v, 8'h14);
    rd(2'd1, v); chk("R6 programmed value", v, 8'h3C);
    @(negedge clk);
    chk("R7 done_pulse one cycle", {7'd0, done_pulse}, 8'h00);
    wr(2'd2, 8'h14);
    rd(2'd2, v); chk("R7 done cleared", v, 8'h04);
    start_store(8'h11, 8'h5A);
    repeat (E + P) @(negedge clk);
    wr(2'd2, 8'h14);
    rd(2'd1, v); chk("R2 data at new pointer", v, 8'h5A);
    wr(2'd0, 8'h10);
    rd(2'd1, v); chk("R2 data at old pointer", v, 8'h3C);
    rd(2'd3, v); chk("R2 key reads zero", v, 8'h00);
  endtask

  task automatic t_key_break();
    logic [7:0] v;
    wr(2'd1, 8'h77);
    wr(2'd3, 8'h55);
    wr(2'd0, 8'h10);
    wr(2'd3, 8'hAA);
    wr(2'd2, 8'h06);
    rd(2'd2, v); chk("R3 interrupted key refused", v, 8'h0C);
    rd(2'd1, v); chk("R8 array unchanged", v, 8'h3C);
    wr(2'd2, 8'h0C);
    wr(2'd3, 8'hAA);
    wr(2'd3, 8'h55);
    wr(2'd2, 8'h06);
    rd(2'd2, v); chk("R3 reversed key refused", v, 8'h0C);
    rd(2'd1, v); chk("R3 array unchanged", v, 8'h3C);
    wr(2'd2, 8'h0C);
    rd(2'd2, v); chk("R8 error cleared", v, 8'h04);
  endtask

  task automatic t_guards();
    logic [7:0] v;
    wr(2'd2, 8'h00);
    unlock();
    wr(2'd2, 8'h06);
    rd(2'd2, v); chk("R4 no prior enable refused", v, 8'h0C);
    rd(2'd1, v); chk("R4 array unchanged", v, 8'h3C);
    wr(2'd2, 8'h8C);
    unlock();
    wr(2'd2, 8'h86);
    rd(2'd2, v); chk("R5 program space refused", v, 8'h8C);
    rd(2'd1, v); chk("R5 array unchanged", v, 8'h3C);
    wr(2'd2, 8'h4C);
    unlock();
    wr(2'd2, 8'h46);
    rd(2'd2, v); chk("R5 config space refused", v, 8'h4C);
    wr(2'd2, 8'h0C);
    rd(2'd2, v); chk("R5 flags cleared", v, 8'h04);
  endtask

  task automatic t_single_use();
    logic [7:0] v;
    wr(2'd2, 8'h84);
    unlock();
    wr(2'd2, 8'h06);
    wr(2'd2, 8'h0C);
    wr(2'd2, 8'h06);
    rd(2'd2, v); chk("R10 reused key refused", v, 8'h0C);
    rd(2'd1, v); chk("R10 array unchanged", v, 8'h3C);
    wr(2'd2, 8'h0C);
    wr(2'd2, 8'h0E);
    rd(2'd2, v); chk("R8 set wins over clear", v, 8'h0C);
    wr(2'd2, 8'h0C);
  endtask

  task automatic t_busy_block();
    logic [7:0] v;
    start_store(8'h20, 8'h99);
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h06);
    repeat (E + P - 3) @(negedge clk);
    chk("R12 single completion", {7'd0, done_pulse}, 8'h01);
    rd(2'd2, v); chk("R12 no error from busy start", v, 8'h14);
    rd(2'd0, v); chk("R9 pointer write blocked", v, 8'h20);
    rd(2'd1, v); chk("R9 data write blocked", v, 8'h99);
    @(negedge clk);
    rd(2'd2, v); chk("R12 no restart", v, 8'h14);
    wr(2'd2, 8'h14);
  endtask

  task automatic t_done_collide();
    logic [7:0] v;
    start_store(8'h21, 8'hC3);
    repeat (E + P - 1) @(negedge clk);
    wr(2'd2, 8'h14);
    chk("R11 pulse on collision edge", {7'd0, done_pulse}, 8'h01);
    rd(2'd2, v); chk("R11 done set wins", v, 8'h14);
    rd(2'd1, v); chk("R11 value stored", v, 8'hC3);
    wr(2'd2, 8'h14);
    rd(2'd2, v); chk("R11 done clears later", v, 8'h04);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_store();
    t_key_break();
    t_guards();
    t_single_use();
    t_busy_block();
    t_done_collide();
    summary();
  end
endmodule